// File: doc/BRIEF.md
# Three-Wire Synthesizer Configuration Port

This block is the configuration slave of a dual frequency synthesizer. A host drives three wires: a serial clock, a serial data line and a latch-enable strobe. The block collects a 24-bit word one bit at a time. When the strobe rises, it writes the word into one of four holding latches. Those latches configure the reference and feedback dividers of the IF and RF loops.

The two lowest bits of each word name the destination latch. The other 22 bits are the payload. A latch changes only when the strobe fires, so the divider configuration stays stable while a new word is being clocked in. The IF and RF feedback latches each carry a power-down flag for their section. The RF reference latch carries the select code for the lock-detect output multiplexer.

The three wires are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and its rising edges are detected in the system clock domain. The serial clock must therefore run below a quarter of the system clock rate.

Top module: `synth_cfg_port`

## Requirements
- R1: While reset is asserted, and after it is released, every latch output, `if_pd`, `rf_pd` and `ld_sel` read zero until the first commit.
- R2: Each rising edge of `ser_clk` shifts one bit of `ser_dat` into a 24-bit register, MSB first. The last bit shifted becomes word bit 0.
- R3: Word bits [1:0] choose the destination: 00 is the IF reference latch (`ifr_q`), 01 the IF feedback latch (`ifn_q`), 10 the RF reference latch (`rfr_q`) and 11 the RF feedback latch (`rfn_q`). Word bits [23:2] are written to that latch.
- R4: A commit leaves the three latches it does not select unchanged.
- R5: No latch changes while bits are being shifted. A latch changes only on a detected rising edge of `ser_le`.
- R6: If more than 24 bits arrive before the strobe, only the last 24 bits form the word.
- R7: `if_pd` equals word bit 23 of the last word committed to the IF feedback latch. `rf_pd` equals word bit 23 of the last word committed to the RF feedback latch. `ld_sel` equals word bits [23:21] of the last word committed to the RF reference latch.
- R8: A `ser_clk` rise and a `ser_le` rise may be detected in the same system cycle. In that case the latch receives the word as it stood before that bit, and the shift still takes place.
- R9: Holding `ser_le` high commits once. Clock edges that arrive while it stays high only shift, and its falling edge commits nothing.
- R10: A rising edge of `ser_le` set up before a system clock edge is visible on the latch outputs after the third system clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, sampled on serial clock rise |
| ser_le | input | 1 | Latch-enable strobe, commits on rise |
| ifr_q | output | 22 | IF reference divider latch |
| ifn_q | output | 22 | IF feedback divider latch |
| rfr_q | output | 22 | RF reference divider latch |
| rfn_q | output | 22 | RF feedback divider latch |
| if_pd | output | 1 | IF section power-down |
| rf_pd | output | 1 | RF section power-down |
| ld_sel | output | 3 | Lock-detect output mux select |

## Verification
A shift and a commit can fall in the same system cycle when the serial clock and the strobe rise together. The bench provokes this by raising both wires on the same edge after a full word has been loaded. It judges the result in two steps. First, the selected latch must hold the word from before the extra bit. Second, a later strobe with no clocks in between must commit the word as it stands after that bit was shifted in.

// File: rtl/synth_cfg_port.sv
module synth_cfg_port #(
  parameter int WORD_W = 24,
  parameter int SEL_W  = 2,
  parameter int SYNC_N = 2,
  parameter int MUX_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ser_clk,
  input  logic                      ser_dat,
  input  logic                      ser_le,
  output logic [WORD_W-SEL_W-1:0]   ifr_q,
  output logic [WORD_W-SEL_W-1:0]   ifn_q,
  output logic [WORD_W-SEL_W-1:0]   rfr_q,
  output logic [WORD_W-SEL_W-1:0]   rfn_q,
  output logic                      if_pd,
  output logic                      rf_pd,
  output logic [MUX_W-1:0]          ld_sel
);
  localparam int PAY_W  = WORD_W - SEL_W;
  localparam int NLAT   = 1 << SEL_W;
  localparam int PD_BIT = PAY_W - 1;

  logic [SYNC_N-1:0] ck_s, dt_s, le_s;
  logic              ck_d, le_d;
  logic [WORD_W-1:0] sr;
  logic [PAY_W-1:0]  lat [NLAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_s <= '0;
      dt_s <= '0;
      le_s <= '0;
      ck_d <= 1'b0;
      le_d <= 1'b0;
    end else begin
      ck_s <= {ck_s[SYNC_N-2:0], ser_clk};
      dt_s <= {dt_s[SYNC_N-2:0], ser_dat};
      le_s <= {le_s[SYNC_N-2:0], ser_le};
      ck_d <= ck_s[SYNC_N-1];
      le_d <= le_s[SYNC_N-1];
    end
  end

  wire ck_rise = ck_s[SYNC_N-1] & ~ck_d;
  wire le_rise = le_s[SYNC_N-1] & ~le_d;
  wire dat_now = dt_s[SYNC_N-1];

  always_ff @(posedge clk) begin
    if (!rst_n)       sr <= '0;
    else if (ck_rise) sr <= {sr[WORD_W-2:0], dat_now};
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NLAT; i++) begin
      if (!rst_n)
        lat[i] <= '0;
      else if (le_rise && sr[SEL_W-1:0] == SEL_W'(i))
        lat[i] <= sr[WORD_W-1:SEL_W];
    end
  end

  assign ifr_q  = lat[0];
  assign ifn_q  = lat[1];
  assign rfr_q  = lat[2];
  assign rfn_q  = lat[3];
  assign if_pd  = lat[1][PD_BIT];
  assign rf_pd  = lat[3][PD_BIT];
  assign ld_sel = lat[2][PAY_W-1 -: MUX_W];

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ck_rise |=> sr[0] == $past(dat_now) && sr[WORD_W-1:1] == $past(sr[WORD_W-2:0]));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> $stable(ifr_q) && $stable(ifn_q) && $stable(rfr_q) && $stable(rfn_q));

  // R4
  single_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ifr_q != $past(ifr_q), ifn_q != $past(ifn_q),
              rfr_q != $past(rfr_q), rfn_q != $past(rfn_q)}));

  // R3
  ifn_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le_rise && sr[SEL_W-1:0] == 2'b01 |=> ifn_q == $past(sr[WORD_W-1:SEL_W]));

  // R3
  rfr_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le_rise && sr[SEL_W-1:0] == 2'b10 |=> rfr_q == $past(sr[WORD_W-1:SEL_W]));

  // R9
  one_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le_rise |=> !le_rise);
endmodule

// File: tb/tb_synth_cfg_port.sv
module tb_synth_cfg_port;
  logic clk = 0, rst_n = 0, ser_clk = 0, ser_dat = 0, ser_le = 0;
  logic [21:0] ifr_q, ifn_q, rfr_q, rfn_q;
  logic if_pd, rf_pd;
  logic [2:0] ld_sel;
  int total = 0, bad = 0;
  bit fin = 0;
  logic [21:0] mdl [4];

  localparam logic [23:0] VEC [8] = '{24'h123450, 24'h8ABCD5, 24'hE0F00E, 24'h7FFFFF,
                                     24'hFFFFFC, 24'h000001, 24'h5A5A5A, 24'hC00003};

  always #5 clk = ~clk;

  synth_cfg_port dut (.clk, .rst_n, .ser_clk, .ser_dat, .ser_le,
    .ifr_q, .ifn_q, .rfr_q, .rfn_q, .if_pd, .rf_pd, .ld_sel);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " ifr"}, 32'(ifr_q), 32'(mdl[0]));
    chk({tag, " ifn"}, 32'(ifn_q), 32'(mdl[1]));
    chk({tag, " rfr"}, 32'(rfr_q), 32'(mdl[2]));
    chk({tag, " rfn"}, 32'(rfn_q), 32'(mdl[3]));
    chk({tag, " R7 if_pd"}, 32'(if_pd), 32'(mdl[1][21]));
    chk({tag, " R7 rf_pd"}, 32'(rf_pd), 32'(mdl[3][21]));
    chk({tag, " R7 ld_sel"}, 32'(ld_sel), 32'(mdl[2][21:19]));
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    ser_dat = b; waitn(4);
    ser_clk = 1; waitn(4);
    ser_clk = 0;
  endtask

  task automatic send_word(logic [23:0] w);
    for (int i = 23; i >= 0; i--) send_bit(w[i]);
    waitn(4);
  endtask

  task automatic strobe();
    ser_le = 1; waitn(8);
    ser_le = 0; waitn(4);
  endtask

  task automatic commit(logic [23:0] w);
    mdl[w[1:0]] = w[23:2];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mdl[i] = '0;
    waitn(3);
    chk_all("R1 in reset");
    rst_n = 1; waitn(3);
    chk_all("R1 after reset");

    // R2 R3 R4 R5 R7: table walk
    for (int v = 0; v < 8; v++) begin
      send_word(VEC[v]);
      chk_all("R5 shifted, no strobe");
      strobe();
      commit(VEC[v]);
      chk_all("R3 R4 vector commit");
    end

    // R6: 6 leading junk bits
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_word(24'h2468AC);
    strobe(); commit(24'h2468AC);
    chk_all("R6 overlong frame");

    // R10: latency of commit
    send_word(24'h3C3C3D);
    ser_le = 1;
    waitn(2);
    chk("R10 not after 2 edges", 32'(ifn_q), 32'(mdl[1]));
    waitn(1);
    commit(24'h3C3C3D);
    chk("R10 after 3 edges", 32'(ifn_q), 32'(mdl[1]));
    waitn(4); ser_le = 0; waitn(4);

    // R9: strobe held high, new word shifted, falling edge
    send_word(24'h111112);
    ser_le = 1; waitn(8);
    commit(24'h111112);
    chk_all("R9 first commit");
    send_word(24'h222226);
    chk_all("R9 held high no recommit");
    ser_le = 0; waitn(8);
    chk_all("R9 falling edge no commit");
    strobe(); commit(24'h222226);
    chk_all("R9 fresh rise commits");

    // R8: shift and commit in the same cycle
    send_word(24'hABCDE7);
    ser_dat = 1'b0; waitn(4);
    ser_clk = 1; ser_le = 1; waitn(8);
    ser_clk = 0; ser_le = 0; waitn(8);
    commit(24'hABCDE7);
    chk_all("R8 commit sees old word");
    strobe(); commit({24'hABCDE7} << 1);
    chk_all("R8 shift also happened");

    // R2 bit order: single-bit marker at MSB
    send_word(24'h800000);
    strobe(); commit(24'h800000);
    chk("R2 MSB first", 32'(ifr_q), 32'h200000);

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule